// File: doc/BRIEF.md
# Error Interrupt Status Unit

This block collects six classes of link error events into a sticky status register and presents it to software in two views. The raw view shows every captured event whatever the enables say. The masked view shows only those captured events whose class is enabled. A single combined interrupt line is raised while any masked bit is set. A separate fatal line is raised while any masked bit of the fatal class is set.

Software reads one of the views and acknowledges the events it has handled by writing ones to the masked-status offset. It selects which classes may interrupt through a pair of registers: one sets enables and the other clears them, so no read-modify-write is needed. The register port is a simple 32-bit write strobe with a byte address, plus a combinational read data bus. Each event input is a one-cycle pulse per class.

The class-to-bit assignment is as follows:

- bit 0: system error
- bit 1: fatal
- bit 2: non-fatal
- bit 3: correctable
- bit 4: bus tag-lookup fatal
- bit 5: ECRC

Top module: `err_irq_status_unit`

## Requirements
- R1: After reset the raw status, masked status and enable mask all read zero, and `irq_o` and `fatal_o` are low.
- R2: A pulse on `evt_in[i]` sets raw status bit i at the next rising clock edge, whether or not class i is enabled. The bit stays set until it is acknowledged. The bit assignment is: bit 0 system, bit 1 fatal, bit 2 non-fatal, bit 3 correctable, bit 4 bus tag-lookup fatal, bit 5 ECRC.
- R3: The register map, as byte addresses, is as follows:
  - 0x1C0: raw status, read-only; writes to it are ignored.
  - 0x1C4: masked status.
  - 0x1C8: enable-set.
  - 0x1CC: enable-clear.
  - Any other address reads zero and ignores writes.
- R4: The masked status reads as the raw status ANDed with the enable mask.
- R5: Writing to 0x1C4 clears every raw bit written as 1 and leaves every bit written as 0 unchanged. The clear acts whether or not the bit is enabled.
- R6: A write to 0x1C8 enables each class written as 1. A write to 0x1CC disables each class written as 1. Zero bits leave the enable mask unchanged, and both offsets read back the current enable mask.
- R7: When an event and an acknowledge hit the same bit in the same cycle, the bit ends up set.
- R8: `irq_o` is high exactly when any masked status bit is set. It changes in the cycle after the edge that updates the status or the enables.
- R9: `fatal_o` is high exactly when masked bit 1 or masked bit 4 is set.
- R10: Read data bits 31 to 6 are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 12 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| evt_in | input | 6 | One-cycle error event pulses, one per class |
| irq_o | output | 1 | Combined error interrupt |
| fatal_o | output | 1 | Fatal-class error indication |

## Verification
The bench builds the block with its default parameters: six classes, a 32-bit data path, a base address of 0x1C0 and a fatal mask of bits 1 and 4. With only six classes, every status pattern has just 64 values. That makes it cheap to sweep all 4096 pairs of enable mask and event pattern. For each pair, an acknowledge pattern is derived from the pair and arrives together with a simultaneous event, so the masked view, both interrupt lines and the set-wins-over-clear rule are covered for every combination. Directed steps add the reset state, ignored writes to the raw and unmapped offsets, and the one-cycle interrupt latency.

// File: rtl/err_irq_pkg.sv
package err_irq_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RAW,
        SEL_MASKED,
        SEL_EN_SET,
        SEL_EN_CLR
    } regsel_e;

endpackage

// File: rtl/err_reg_decode.sv
module err_reg_decode
    import err_irq_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h1C0
) (
    input  logic [ADDR_W-1:0] addr,
    output regsel_e           sel
);
    localparam logic [ADDR_W-1:0] A_RAW    = BASE_ADDR;
    localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(BASE_ADDR + 4);
    localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(BASE_ADDR + 8);
    localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(BASE_ADDR + 12);

    always_comb begin
        sel = SEL_NONE;
        if (addr == A_RAW)         sel = SEL_RAW;
        else if (addr == A_MASKED) sel = SEL_MASKED;
        else if (addr == A_EN_SET) sel = SEL_EN_SET;
        else if (addr == A_EN_CLR) sel = SEL_EN_CLR;
    end
endmodule

// File: rtl/err_status_bank.sv
module err_status_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] status_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          bit_q <= 1'b0;
            else if (set_i[i])   bit_q <= 1'b1;   // event wins over acknowledge
            else if (clr_i[i])   bit_q <= 1'b0;
        end
        assign status_o[i] = bit_q;
    end
endmodule

// File: rtl/err_enable_bank.sv
module err_enable_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] en_set_i,
    input  logic [N-1:0] en_clr_i,
    output logic [N-1:0] enable_o
);
    logic [N-1:0] en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q & ~en_clr_i) | en_set_i;
    end

    assign enable_o = en_q;
endmodule

// File: rtl/err_irq_status_unit.sv
module err_irq_status_unit
    import err_irq_pkg::*;
#(
    parameter int                     NUM_CLASSES = 6,
    parameter int                     DATA_W      = 32,
    parameter int                     ADDR_W      = 12,
    parameter logic [ADDR_W-1:0]      BASE_ADDR   = 12'h1C0,
    parameter logic [NUM_CLASSES-1:0] FATAL_MASK  = NUM_CLASSES'('h12)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    input  logic [NUM_CLASSES-1:0] evt_in,
    output logic                   irq_o,
    output logic                   fatal_o
);
    localparam int N = NUM_CLASSES;

    regsel_e      sel;
    logic [N-1:0] wbits;
    logic [N-1:0] ack_bits;
    logic [N-1:0] en_set_bits;
    logic [N-1:0] en_clr_bits;
    logic [N-1:0] status_q;
    logic [N-1:0] enable_q;
    logic [N-1:0] masked;
    logic         unused_wdata_hi;

    err_reg_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr (reg_addr),
        .sel  (sel)
    );

    assign wbits           = reg_wdata[N-1:0];
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:N];
    assign ack_bits        = (reg_we && sel == SEL_MASKED) ? wbits : '0;
    assign en_set_bits     = (reg_we && sel == SEL_EN_SET) ? wbits : '0;
    assign en_clr_bits     = (reg_we && sel == SEL_EN_CLR) ? wbits : '0;

    err_status_bank #(.N(N)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (evt_in),
        .clr_i    (ack_bits),
        .status_o (status_q)
    );

    err_enable_bank #(.N(N)) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_set_i (en_set_bits),
        .en_clr_i (en_clr_bits),
        .enable_o (enable_q)
    );

    assign masked  = status_q & enable_q;
    assign irq_o   = |masked;
    assign fatal_o = |(masked & FATAL_MASK);

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_RAW:    reg_rdata[N-1:0] = status_q;
            SEL_MASKED: reg_rdata[N-1:0] = masked;
            SEL_EN_SET: reg_rdata[N-1:0] = enable_q;
            SEL_EN_CLR: reg_rdata[N-1:0] = enable_q;
            SEL_NONE:   reg_rdata        = '0;
        endcase
    end
endmodule

// File: rtl/err_irq_status_sva.sv
module err_irq_status_sva #(
    parameter int                     N          = 6,
    parameter int                     DATA_W     = 32,
    parameter int                     ADDR_W     = 12,
    parameter logic [ADDR_W-1:0]      BASE_ADDR  = 12'h1C0,
    parameter logic [N-1:0]           FATAL_MASK = N'('h12)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [N-1:0]      evt_in,
    input logic              irq_o,
    input logic              fatal_o,
    input logic [N-1:0]      raw_q,
    input logic [N-1:0]      en_q
);
    localparam logic [ADDR_W-1:0] A_RAW = BASE_ADDR;
    localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(BASE_ADDR + 4);
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(BASE_ADDR + 8);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(BASE_ADDR + 12);

    assert_event_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in != '0) |=> ((raw_q & $past(evt_in)) == $past(evt_in)));

    assert_raw_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_RAW && evt_in == '0) |=> $stable(raw_q));

    // R5 and R7: acknowledged bits clear unless an event arrived alongside
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_ACK) |=>
            ((raw_q & $past(reg_wdata[N-1:0]) & ~$past(evt_in)) == '0));

    assert_enable_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_SET) |=>
            ((en_q & $past(reg_wdata[N-1:0])) == $past(reg_wdata[N-1:0])));

    assert_enable_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_CLR) |=> ((en_q & $past(reg_wdata[N-1:0])) == '0));

    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(evt_in != '0 || (reg_we && reg_addr == A_SET)));

    assert_fatal_implies_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |-> (irq_o && ((raw_q & FATAL_MASK) != '0)));

    assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:N] == '0);
endmodule

bind err_irq_status_unit err_irq_status_sva #(
    .N          (NUM_CLASSES),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .BASE_ADDR  (BASE_ADDR),
    .FATAL_MASK (FATAL_MASK)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_in    (evt_in),
    .irq_o     (irq_o),
    .fatal_o   (fatal_o),
    .raw_q     (status_q),
    .en_q      (enable_q)
);

// File: tb/sim_err_irq_status_unit.sv
module sim_err_irq_status_unit;
    localparam logic [11:0] A_RAW = 12'h1C0;
    localparam logic [11:0] A_ACK = 12'h1C4;
    localparam logic [11:0] A_SET = 12'h1C8;
    localparam logic [11:0] A_CLR = 12'h1CC;
    localparam logic [5:0]  FMASK = 6'h12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  evt_in = '0;
    logic        irq_o;
    logic        fatal_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    err_irq_status_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_in    (evt_in),
        .irq_o     (irq_o),
        .fatal_o   (fatal_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock cycle of stimulus, applied from one falling edge to the next
    task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d,
                        input logic [5:0] ev);
        reg_we    = we;
        reg_addr  = a;
        reg_wdata = d;
        evt_in    = ev;
        @(negedge clk);
        reg_we    = 1'b0;
        evt_in    = '0;
        reg_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(A_RAW, v); chk("R1 raw", v, 0);
        rd(A_ACK, v); chk("R1 masked", v, 0);
        rd(A_SET, v); chk("R1 enable", v, 0);
        chk("R1 irq", {31'b0, irq_o}, 0);
        chk("R1 fatal", {31'b0, fatal_o}, 0);

        // R10: upper bits zero even after writing ones everywhere
        step(1, A_SET, 32'hFFFF_FFFF, 0);
        rd(A_SET, v); chk("R10 enable upper bits", v, 32'h3F);

        // R8: irq latency, enabled event pulse
        reg_addr = A_RAW;
        evt_in = 6'h08;
        #1 chk("R8 irq before edge", {31'b0, irq_o}, 0);
        @(negedge clk);
        evt_in = '0;
        chk("R8 irq after edge", {31'b0, irq_o}, 1);
        chk("R9 no fatal for correctable", {31'b0, fatal_o}, 0);

        // R3: writes to raw and unmapped offsets are ignored
        step(1, A_RAW, 32'h3F, 0);
        rd(A_RAW, v); chk("R3 raw write ignored", v, 32'h08);
        step(1, 12'h1D0, 32'h3F, 0);
        rd(A_RAW, v); chk("R3 unmapped write keeps status", v, 32'h08);
        rd(A_SET, v); chk("R3 unmapped write keeps enable", v, 32'h3F);
        rd(12'h1D0, v); chk("R3 unmapped reads zero", v, 0);
        rd(12'h1C2, v); chk("R3 unaligned reads zero", v, 0);

        // R6: zero bits leave enables alone
        step(1, A_SET, 0, 0);
        rd(A_CLR, v); chk("R6 zero set no effect", v, 32'h3F);
        step(1, A_CLR, 0, 0);
        rd(A_SET, v); chk("R6 zero clear no effect", v, 32'h3F);

        // sweep every enable mask against every event pattern
        for (int en = 0; en < 64; en++) begin
            for (int ev = 0; ev < 64; ev++) begin
                logic [5:0] e, x, a, b, m, r;
                e = 6'(en);
                x = 6'(ev);
                a = x ^ {e[2:0], e[5:3]};
                b = e & 6'h21;
                step(1, A_CLR, 32'h3F, 0);
                step(1, A_ACK, 32'h3F, 0);
                step(1, A_SET, {26'b0, e}, 0);
                step(0, A_RAW, 0, x);
                m = x & e;
                rd(A_RAW, v); chk("R2 raw latch", v, {26'b0, x});
                rd(A_ACK, v); chk("R4 masked view", v, {26'b0, m});
                rd(A_CLR, v); chk("R6 enable readback", v, {26'b0, e});
                chk("R8 irq", {31'b0, irq_o}, {31'b0, |m});
                chk("R9 fatal", {31'b0, fatal_o}, {31'b0, |(m & FMASK)});
                // R5 acknowledge with R7 simultaneous event
                step(1, A_ACK, {26'b0, a}, b);
                r = (x & ~a) | b;
                rd(A_RAW, v); chk("R5 R7 after acknowledge", v, {26'b0, r});
                chk("R8 irq after acknowledge", {31'b0, irq_o}, {31'b0, |(r & e)});
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule